// File: doc/BRIEF.md
# Two-Row Keypad Scanner with Hotkey Detect

This block reads a six-key pad wired as two rows of three columns. A single-cycle request starts one scan: the block selects the upper row, lets the lines settle, captures the three column lines, then selects the lower row, settles again and captures the columns once more. Column lines are active low, and each one passes through a two-flop synchronizer before it is captured.

When the scan finishes, the block publishes a 6-bit vector of held keys. Each key position drives a fixed bit of that vector, and the bit order does not follow the scan order. The block also raises a recovery flag when a fixed three-key chord is among the held keys, and it gives a small boot-delay code. Boot firmware or a sequencer reads these results after the done pulse. They stay unchanged until the next scan completes.

Top module: `kp_scan`

## Requirements
- R1: `row_lo` low selects the upper row and high selects the lower row. After reset, and whenever no scan is running, it rests high.
- R2: With W = SETTLE_CYC + 2, an accepted request moves `row_lo` low from the next cycle. `row_lo` goes high W cycles later, and `scan_done` is high for exactly one cycle W cycles after that. Every row is therefore held for at least SETTLE_CYC cycles before its synchronized columns are captured.
- R3: The upper row is captured first and the lower row second, in every scan.
- R4: `col_n[i]` low means the key in column i of the selected row is held. Columns reach the capture logic through a two-stage synchronizer.
- R5: Upper row: column 0 sets `keys[5]`, column 1 sets `keys[3]`, column 2 sets `keys[4]`.
- R6: Lower row: column 0 sets `keys[2]`, column 1 sets `keys[1]`, column 2 sets `keys[0]`.
- R7: `rcv_req` is 1 exactly when `keys[5]`, `keys[3]` and `keys[0]` are all 1 (chord mask 6'b101001). Extra held keys do not clear it.
- R8: `boot_dly` is 0 when `rcv_req` is 1 or `keys` is zero, and 2 otherwise.
- R9: `keys`, `rcv_req` and `boot_dly` change only in the cycle in which `scan_done` is high. Key changes between scans do not alter them.
- R10: A request that arrives while a scan is running has no effect: the timing of that scan is unchanged and no second done pulse follows.
- R11: During reset `keys` is 0, `rcv_req` is 0, `boot_dly` is 0, `scan_done` is 0 and `row_lo` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_go | input | 1 | One-cycle scan request |
| row_lo | output | 1 | Row select: 0 upper, 1 lower |
| col_n | input | 3 | Column lines, active low, bit i is column i |
| scan_done | output | 1 | One-cycle pulse when fresh results are valid |
| keys | output | 6 | Held-key vector |
| rcv_req | output | 1 | Recovery chord detected |
| boot_dly | output | DLY_W | Boot-delay code (0 or DLY_HELD) |

## Verification
The assertions assume that `scan_go` is only ever a one-cycle pulse. They also assume the column lines follow the selected row as a keypad would, so the lower-row values are present for the whole lower settle window. The stimulus meets these assumptions by modelling the pad combinationally from `row_lo` and a key set that changes only between scans. Requests are driven on falling edges as single-cycle pulses, including one pulse placed deliberately inside a running scan.

// File: rtl/kp_scan_pkg.sv
package kp_scan_pkg;

  localparam int NCOL = 3;
  localparam int NKEY = 2 * NCOL;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_UPPER = 2'd1,
    ST_LOWER = 2'd2
  } scan_st_e;

  // chord that requests recovery: bits 5, 3 and 0
  localparam logic [NKEY-1:0] CHORD_MASK = 6'b101001;

  // upper row: col0 -> bit5, col1 -> bit3, col2 -> bit4
  function automatic logic [NKEY-1:0] place_upper(input logic [NCOL-1:0] p);
    logic [NKEY-1:0] v;
    v    = '0;
    v[5] = p[0];
    v[3] = p[1];
    v[4] = p[2];
    return v;
  endfunction

  // lower row: col0 -> bit2, col1 -> bit1, col2 -> bit0
  function automatic logic [NKEY-1:0] place_lower(input logic [NCOL-1:0] p);
    logic [NKEY-1:0] v;
    v    = '0;
    v[2] = p[0];
    v[1] = p[1];
    v[0] = p[2];
    return v;
  endfunction

endpackage

// File: rtl/kp_rst_sync.sv
module kp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/kp_col_sync.sv
module kp_col_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) sh_q <= '1;   // idle column reads released
      else         sh_q <= {sh_q[STAGES-2:0], d_async[i]};
    end
    assign d_sync[i] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/kp_settle_timer.sv
module kp_settle_timer #(
  parameter int WAIT = 6
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(WAIT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(WAIT - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (load)             cnt_nxt = RELOAD;
    else if (cnt_q != '0) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cnt_q <= '0;
    else         cnt_q <= cnt_nxt;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/kp_key_decode.sv
module kp_key_decode
  import kp_scan_pkg::*;
#(
  parameter int DLY_W    = 2,
  parameter int DLY_HELD = 2
) (
  input  logic [NCOL-1:0]  up_press,
  input  logic [NCOL-1:0]  lo_press,
  output logic [NKEY-1:0]  vec,
  output logic             chord,
  output logic [DLY_W-1:0] dly
);
  always_comb begin
    vec   = place_upper(up_press) | place_lower(lo_press);
    chord = ((vec & CHORD_MASK) == CHORD_MASK);
    if (chord || (vec == '0)) dly = '0;
    else                      dly = DLY_W'(DLY_HELD);
  end
endmodule

// File: rtl/kp_scan.sv
module kp_scan
  import kp_scan_pkg::*;
#(
  parameter int SETTLE_CYC  = 2000,
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 2,
  parameter int DLY_HELD    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_go,
  output logic             row_lo,
  input  logic [2:0]       col_n,
  output logic             scan_done,
  output logic [5:0]       keys,
  output logic             rcv_req,
  output logic [DLY_W-1:0] boot_dly
);
  localparam int WAIT = SETTLE_CYC + SYNC_STAGES;

  logic rst_sn;
  logic [NCOL-1:0] col_s, press;
  logic tmr_load, tmr_zero;

  scan_st_e st_q, st_nxt;
  logic row_q, row_nxt;
  logic done_q, done_nxt;
  logic up_en, res_en;
  logic [NCOL-1:0] up_q;
  logic [NKEY-1:0] keys_q, dec_vec;
  logic rcv_q, dec_chord;
  logic [DLY_W-1:0] dly_q, dec_dly;

  kp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  kp_col_sync #(.WIDTH(NCOL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_sn(rst_sn), .d_async(col_n), .d_sync(col_s)
  );

  assign press = ~col_s;

  kp_settle_timer #(.WAIT(WAIT)) u_tmr (
    .clk(clk), .rst_sn(rst_sn), .load(tmr_load), .expired(tmr_zero)
  );

  kp_key_decode #(.DLY_W(DLY_W), .DLY_HELD(DLY_HELD)) u_dec (
    .up_press(up_q), .lo_press(press),
    .vec(dec_vec), .chord(dec_chord), .dly(dec_dly)
  );

  // next-state logic
  always_comb begin
    st_nxt   = st_q;
    row_nxt  = row_q;
    done_nxt = 1'b0;
    up_en    = 1'b0;
    res_en   = 1'b0;
    tmr_load = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (scan_go) begin
          st_nxt   = ST_UPPER;
          row_nxt  = 1'b0;
          tmr_load = 1'b1;
        end
      end
      ST_UPPER: begin
        if (tmr_zero) begin
          up_en    = 1'b1;
          row_nxt  = 1'b1;
          tmr_load = 1'b1;
          st_nxt   = ST_LOWER;
        end
      end
      ST_LOWER: begin
        if (tmr_zero) begin
          res_en   = 1'b1;
          done_nxt = 1'b1;
          st_nxt   = ST_IDLE;
        end
      end
      default: begin
        st_nxt  = ST_IDLE;
        row_nxt = 1'b1;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      row_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      row_q  <= row_nxt;
      done_q <= done_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    up_q <= '0;
    else if (up_en) up_q <= press;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      keys_q <= '0;
      rcv_q  <= 1'b0;
      dly_q  <= '0;
    end else if (res_en) begin
      keys_q <= dec_vec;
      rcv_q  <= dec_chord;
      dly_q  <= dec_dly;
    end
  end

  assign row_lo    = row_q;
  assign scan_done = done_q;
  assign keys      = keys_q;
  assign rcv_req   = rcv_q;
  assign boot_dly  = dly_q;
endmodule

// File: rtl/kp_scan_chk.sv
module kp_scan_chk #(
  parameter int SETTLE_CYC = 2000,
  parameter int DLY_W      = 2,
  parameter int DLY_HELD   = 2
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             scan_go,
  input logic             row_lo,
  input logic             scan_done,
  input logic [5:0]       keys,
  input logic             rcv_req,
  input logic [DLY_W-1:0] boot_dly
);
  logic        prev_row_q;
  int unsigned held_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      prev_row_q <= 1'b1;
      held_q     <= 0;
    end else begin
      prev_row_q <= row_lo;
      if (row_lo != prev_row_q) held_q <= 0;
      else if (held_q < 32'h7fff_ffff) held_q <= held_q + 1;
    end
  end

  p_done_on_lower_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    scan_done |-> row_lo);

  p_settle_window_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    scan_done |-> (held_q >= SETTLE_CYC));

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    scan_done |=> !scan_done);

  p_upper_after_go_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(row_lo) |-> $past(scan_go));

  p_chord_bits_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    rcv_req |-> (keys[5] && keys[3] && keys[0]));

  p_delay_zero_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (rcv_req || keys == '0) |-> (boot_dly == '0));

  p_delay_code_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (boot_dly == '0) || (boot_dly == DLY_W'(DLY_HELD)));

  p_results_hold_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !scan_done |-> $stable({keys, rcv_req, boot_dly}));
endmodule

bind kp_scan kp_scan_chk #(
  .SETTLE_CYC(SETTLE_CYC), .DLY_W(DLY_W), .DLY_HELD(DLY_HELD)
) u_chk (
  .clk(clk), .rst_sn(rst_sn), .scan_go(scan_go), .row_lo(row_lo),
  .scan_done(scan_done), .keys(keys), .rcv_req(rcv_req), .boot_dly(boot_dly)
);

// File: tb/kp_scan_test.sv
module kp_scan_test;
  localparam int S = 4;
  localparam int W = S + 2;

  logic       clk;
  logic       rst_n;
  logic       scan_go;
  logic [2:0] col_n;
  logic       row_lo, scan_done, rcv_req;
  logic [5:0] keys;
  logic [1:0] boot_dly;

  logic [5:0] kv;     // bench key set, in result-vector bit positions
  int tests, fails;
  bit cmp_on;

  kp_scan #(.SETTLE_CYC(S)) uut (
    .clk(clk), .rst_n(rst_n), .scan_go(scan_go), .row_lo(row_lo),
    .col_n(col_n), .scan_done(scan_done), .keys(keys),
    .rcv_req(rcv_req), .boot_dly(boot_dly)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // keypad model: pressed key pulls its column low in the selected row
  assign col_n = row_lo ? ~{kv[0], kv[1], kv[2]} : ~{kv[4], kv[3], kv[5]};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit       m_busy, m_row, m_done, m_rec;
  int       m_t;
  logic [5:0] m_vec;
  logic [1:0] m_dly;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_row <= 1; m_done <= 0; m_t <= 0;
      m_vec <= 0; m_rec <= 0; m_dly <= 0;
    end else begin
      m_done <= 0;
      if (!m_busy) begin
        if (scan_go) begin m_busy <= 1; m_t <= 1; m_row <= 0; end
      end else begin
        m_t <= m_t + 1;
        if (m_t == W) m_row <= 1;
        if (m_t == 2 * W) begin
          m_busy <= 0;
          m_done <= 1;
          m_vec  <= kv;
          m_rec  <= kv[5] & kv[3] & kv[0];
          m_dly  <= ((kv[5] & kv[3] & kv[0]) || kv == 0) ? 2'd0 : 2'd2;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(row_lo == m_row, "R1", "row_lo vs model", row_lo, m_row);
      chk(scan_done == m_done, "R2", "scan_done vs model", scan_done, m_done);
      chk(keys == m_vec, "R9", "keys vs model", keys, m_vec);
      chk(rcv_req == m_rec, "R7", "rcv_req vs model", rcv_req, m_rec);
      chk(boot_dly == m_dly, "R8", "boot_dly vs model", boot_dly, m_dly);
    end
  end

  task automatic scan(input logic [5:0] k, input int extra_at, input string req);
    int n;
    bit got;
    logic exp_rec;
    logic [1:0] exp_dly;
    kv = k;
    scan_go = 1'b1;
    n = 0;
    got = 0;
    while (!got && n < 200) begin
      @(negedge clk);
      n++;
      scan_go = (n == extra_at);
      if (n == 1)     chk(row_lo == 1'b0, "R3", "upper row first", row_lo, 0);
      if (n == W)     chk(row_lo == 1'b0, "R2", "upper held", row_lo, 0);
      if (n == W + 1) chk(row_lo == 1'b1, "R1", "lower row second", row_lo, 1);
      if (scan_done) got = 1;
    end
    exp_rec = k[5] & k[3] & k[0];
    exp_dly = (exp_rec || k == 0) ? 2'd0 : 2'd2;
    chk(n == 2 * W + 1, "R2", "cycles to done", n, 2 * W + 1);
    chk(keys == k, req, "key vector", keys, k);
    chk(rcv_req == exp_rec, "R7", "recovery flag", rcv_req, exp_rec);
    chk(boot_dly == exp_dly, "R8", "boot delay", boot_dly, exp_dly);
    @(negedge clk);
    chk(scan_done == 1'b0, "R2", "done one cycle", scan_done, 0);
  endtask

  initial begin
    tests = 0; fails = 0; cmp_on = 0;
    rst_n = 1'b0; scan_go = 1'b0; kv = '0;
    repeat (3) @(negedge clk);
    // R11 reset values
    chk(keys == 0, "R11", "keys in reset", keys, 0);
    chk(rcv_req == 0, "R11", "rcv_req in reset", rcv_req, 0);
    chk(boot_dly == 0, "R11", "boot_dly in reset", boot_dly, 0);
    chk(scan_done == 0, "R11", "done in reset", scan_done, 0);
    chk(row_lo == 1, "R11", "row_lo in reset", row_lo, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    scan(6'b000000, 0, "R8");
    // single keys: upper col0/col1/col2, lower col0/col1/col2 (R5, R6, R4)
    scan(6'b100000, 0, "R5");
    scan(6'b001000, 0, "R5");
    scan(6'b010000, 0, "R5");
    scan(6'b000100, 0, "R6");
    scan(6'b000010, 0, "R6");
    scan(6'b000001, 0, "R6");
    scan(6'b101001, 0, "R7");
    scan(6'b111111, 0, "R7");
    scan(6'b101000, 0, "R7");
    scan(6'b110110, 0, "R4");

    // R10: request in mid upper and mid lower phase
    scan(6'b010010, 3, "R10");
    scan(6'b001001, W + 3, "R10");
    for (int i = 0; i < 3 * W; i++) begin
      @(negedge clk);
      chk(scan_done == 1'b0, "R10", "no extra done", scan_done, 0);
    end

    // R9: keys change between scans, results hold
    scan(6'b000110, 0, "R9");
    kv = 6'b111111;
    repeat (20) @(negedge clk);
    chk(keys == 6'b000110, "R9", "keys held", keys, 6'b000110);
    chk(rcv_req == 1'b0, "R9", "rcv held", rcv_req, 0);
    chk(boot_dly == 2'd2, "R9", "dly held", boot_dly, 2);
    chk(row_lo == 1'b1, "R1", "idle row", row_lo, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule